// File: doc/BRIEF.md
# Field-Programmable Logic Array Core

This block is a reconfigurable sum-of-products array with N_IN inputs, N_PT product terms and N_OUT outputs. The defaults are 3, 4 and 2, and it also builds at 16, 48 and 8. A buffer/inverter stage turns every input into a true literal and a complemented literal. A programmable AND plane chooses which literals form each product term. A programmable OR plane chooses which terms feed each output. A programmable true/complement stage then sets the polarity of every output. The path from `in_x` to `out_f` is purely combinational.

The connection map is held in a fuse image of N_PT·2·N_IN + N_PT·N_OUT + N_OUT bits. A stored 1 is an intact fuse and a stored 0 is a blown fuse. Reset and `erase` both restore every fuse to intact, which is the blank state. The image is loaded one bit per accepted beat over a valid/ready stream. Back-pressure works as follows: `ld_rdy` drops while `erase` is high and stays low once the image is complete. It comes back only after an erase, so a programmed array cannot be overwritten without first being erased. The array's outputs read 0 until the image is complete, which is signalled by `cfg_ok`.

Top module: `pla_core`

## Requirements
- R1: After reset, `cfg_ok` is 0, `ld_rdy` is 1 and `out_f` is all zeros for every `in_x`.
- R2: A beat is taken only on a rising edge where `ld_vld` and `ld_rdy` are both 1. Cycles with `ld_vld` low shift nothing, whatever `ld_bit` carries.
- R3: The image is sent first bit first, in this order: the AND row of term 0 to term N_PT-1, then the OR row of term 0 to term N_PT-1, then the polarity field. Each row and field is sent from its highest bit down. `cfg_ok` goes high on the edge that takes the final beat (beat number N_PT·2·N_IN+N_PT·N_OUT+N_OUT) and not earlier.
- R4: In an AND row, bit 2i is the true literal of `in_x[i]` and bit 2i+1 is its complement. A product term is the AND of every literal whose bit is 1.
- R5: A term whose AND row is all ones evaluates to 0. A term whose AND row is all zeros evaluates to 1.
- R6: Bit j of a term's OR row connects that term to output j. An output with no connected terms evaluates to 0 before the polarity stage.
- R7: Polarity bit j set to 1 passes output j true. Set to 0, it drives the complement of the sum.
- R8: While `cfg_ok` is 0, including partway through a load, `out_f` is 0 for every input.
- R9: `erase` restores every fuse to 1 and clears `cfg_ok` and the beat count on the next edge. If a beat is offered in the same cycle as `erase`, the beat is refused (`ld_rdy` is 0 while `erase` is high).
- R10: `out_f` follows a change on `in_x` with no clock edge in between.
- R11: While `cfg_ok` is 1, `ld_rdy` is 0 and offered beats leave the outputs unchanged until the next erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, returns the array to blank |
| erase | input | 1 | Restore all fuses to intact and restart the load |
| ld_vld | input | 1 | Load stream beat valid |
| ld_bit | input | 1 | Load stream data bit |
| ld_rdy | output | 1 | Load stream ready |
| in_x | input | N_IN | Logic inputs |
| out_f | output | N_OUT | Logic outputs |
| cfg_ok | output | 1 | Image complete, array live |

## Verification
Two functions can fall in the same cycle: an erase and a load beat. The bench provokes this by raising `erase` and `ld_vld` together partway through a load. A refused beat is one that does not count toward the image, so the bench then sends exactly one beat short of a full image and checks that `cfg_ok` is still low. It then sends the final beat and checks that `cfg_ok` rises. The loaded functions are judged by sweeping all input combinations against minterm masks computed in the bench, in both true and complemented polarity.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Load progress of the fuse image.
  typedef enum logic [1:0] {
    CS_BLANK = 2'd0,
    CS_FILL  = 2'd1,
    CS_DONE  = 2'd2
  } cfg_state_e;

  // Total fuse count: AND plane, then OR plane, then polarity field.
  function automatic int unsigned pla_image_bits(input int unsigned n_in,
                                                 input int unsigned n_pt,
                                                 input int unsigned n_out);
    return n_pt * 2 * n_in + n_pt * n_out + n_out;
  endfunction

endpackage

// File: rtl/pla_fuse_store.sv
module pla_fuse_store #(
  parameter int unsigned N_IN  = 3,
  parameter int unsigned N_PT  = 4,
  parameter int unsigned N_OUT = 2,
  localparam int unsigned IMG_W = pla_pkg::pla_image_bits(N_IN, N_PT, N_OUT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase,
  input  logic             shift_en,
  input  logic             shift_bit,
  output logic [IMG_W-1:0] img,
  output logic             programmed
);
  import pla_pkg::*;

  localparam int unsigned CNT_W = $clog2(IMG_W + 1);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(IMG_W - 1);

  cfg_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img   <= '1;
      cnt_q <= '0;
      st_q  <= CS_BLANK;
    end else if (erase) begin
      img   <= '1;
      cnt_q <= '0;
      st_q  <= CS_BLANK;
    end else if (shift_en) begin
      img <= {img[IMG_W-2:0], shift_bit};
      if (cnt_q == LAST_BEAT) begin
        cnt_q <= '0;
        st_q  <= CS_DONE;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        st_q  <= CS_FILL;
      end
    end
  end

  assign programmed = (st_q == CS_DONE);

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_IN = 3,
  parameter int unsigned N_PT = 4,
  localparam int unsigned ROW_W = 2 * N_IN
) (
  input  logic [N_IN-1:0]       x,
  input  logic [N_PT*ROW_W-1:0] and_map,
  output logic [N_PT-1:0]       prod
);

  logic [ROW_W-1:0] lit;

  // Buffer/inverter stage: both polarities of every input.
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = x[i];
    assign lit[2*i+1] = ~x[i];
  end

  // Term 0 sits in the highest row of the map.
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [ROW_W-1:0] row;
    assign row     = and_map[(N_PT-1-t)*ROW_W +: ROW_W];
    assign prod[t] = &(~row | lit);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_PT  = 4,
  parameter int unsigned N_OUT = 2
) (
  input  logic [N_PT-1:0]       prod,
  input  logic [N_PT*N_OUT-1:0] or_map,
  input  logic [N_OUT-1:0]      pol,
  input  logic                  live,
  output logic [N_OUT-1:0]      f
);

  logic [N_OUT-1:0][N_PT-1:0] col;

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    for (genvar t = 0; t < N_PT; t++) begin : g_conn
      assign col[j][t] = or_map[(N_PT-1-t)*N_OUT + j];
    end
    logic sum;
    assign sum  = |(prod & col[j]);
    // Intact polarity fuse feeds 0 into the XOR: true output.
    assign f[j] = live & (sum ^ ~pol[j]);
  end

endmodule

// File: rtl/pla_core.sv
module pla_core #(
  parameter int unsigned N_IN  = 3,
  parameter int unsigned N_PT  = 4,
  parameter int unsigned N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase,
  input  logic             ld_vld,
  input  logic             ld_bit,
  output logic             ld_rdy,
  input  logic [N_IN-1:0]  in_x,
  output logic [N_OUT-1:0] out_f,
  output logic             cfg_ok
);

  localparam int unsigned ROW_W = 2 * N_IN;
  localparam int unsigned AND_W = N_PT * ROW_W;
  localparam int unsigned OR_W  = N_PT * N_OUT;
  localparam int unsigned IMG_W = pla_pkg::pla_image_bits(N_IN, N_PT, N_OUT);

  logic [IMG_W-1:0] img;
  logic [N_PT-1:0]  prod;
  logic             programmed;

  assign ld_rdy = ~programmed & ~erase;
  assign cfg_ok = programmed;

  pla_fuse_store #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .erase      (erase),
    .shift_en   (ld_vld & ld_rdy),
    .shift_bit  (ld_bit),
    .img        (img),
    .programmed (programmed)
  );

  pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .x       (in_x),
    .and_map (img[IMG_W-1 -: AND_W]),
    .prod    (prod)
  );

  pla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .prod   (prod),
    .or_map (img[N_OUT+OR_W-1 -: OR_W]),
    .pol    (img[N_OUT-1:0]),
    .live   (programmed),
    .f      (out_f)
  );

endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk #(
  parameter int unsigned N_IN  = 3,
  parameter int unsigned N_OUT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             erase,
  input logic             ld_vld,
  input logic             ld_rdy,
  input logic [N_IN-1:0]  in_x,
  input logic [N_OUT-1:0] out_f,
  input logic             cfg_ok
);

  // R8: an incomplete image keeps every output low.
  a_r8_quiet_until_live: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |-> out_f == '0);

  // R9: erase drops the complete flag on the next edge.
  a_r9_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> !cfg_ok);

  // R9: no beat is taken while erase is high.
  a_r9_no_beat_in_erase: assert property (@(posedge clk) disable iff (!rst_n)
    erase |-> !ld_rdy);

  // R3: completion only follows an accepted beat.
  a_r3_rise_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_ok) |-> $past(ld_vld && ld_rdy && !erase));

  // R11: a programmed array stays programmed until erased.
  a_r11_hold_live: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok && !erase |=> cfg_ok);

  // R11: no back door for loading once programmed.
  a_r11_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> !ld_rdy);

  // R2: without an accepted beat the image cannot complete.
  a_r2_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok && !(ld_vld && ld_rdy) |=> !cfg_ok);

  // R10: outputs held steady when neither inputs nor state move.
  a_r10_stable_eval: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok && $past(cfg_ok) && $stable(in_x) |-> $stable(out_f));

endmodule

bind pla_core pla_core_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .erase  (erase),
  .ld_vld (ld_vld),
  .ld_rdy (ld_rdy),
  .in_x   (in_x),
  .out_f  (out_f),
  .cfg_ok (cfg_ok)
);

// File: tb/tb_pla_core.sv
module tb_pla_core;
  localparam int IMG_W = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic erase = 1'b0;
  logic ld_vld = 1'b0;
  logic ld_bit = 1'b0;
  logic ld_rdy;
  logic [2:0] in_x = '0;
  logic [1:0] out_f;
  logic cfg_ok;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pla_core dut (
    .clk(clk), .rst_n(rst_n), .erase(erase), .ld_vld(ld_vld), .ld_bit(ld_bit),
    .ld_rdy(ld_rdy), .in_x(in_x), .out_f(out_f), .cfg_ok(cfg_ok)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // AND row: bit 2i keeps true literal i, bit 2i+1 keeps complement (R4).
  function automatic logic [5:0] arow(input logic [2:0] kt, input logic [2:0] kc);
    logic [5:0] r;
    for (int i = 0; i < 3; i++) begin
      r[2*i]   = kt[i];
      r[2*i+1] = kc[i];
    end
    return r;
  endfunction

  task automatic send(input logic b);
    @(negedge clk);
    ld_vld = 1'b1;
    ld_bit = b;
    @(posedge clk);
    #1 ld_vld = 1'b0;
  endtask

  // Sends image bits hi..lo, with idle gaps carrying junk data (R2).
  task automatic send_range(input logic [IMG_W-1:0] img, input int hi, input int lo);
    for (int k = hi; k >= lo; k--) begin
      if (k % 5 == 0) begin
        @(negedge clk);
        ld_vld = 1'b0;
        ld_bit = ~img[k];
        @(posedge clk);
      end
      send(img[k]);
    end
  endtask

  task automatic do_erase();
    @(negedge clk);
    erase = 1'b1;
    @(posedge clk);
    #1 erase = 1'b0;
  endtask

  // Sweep all inputs; expected outputs come from minterm masks (R10).
  task automatic sweep(input string tag, input logic [7:0] m0, input logic [7:0] m1);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      in_x = 3'(v);
      #1 chk(tag, {6'd0, out_f}, {6'd0, m1[v], m0[v]});
    end
  endtask

  localparam logic [7:0] F1 = 8'hB6;  // minterms 1,2,4,5,7
  localparam logic [7:0] F2 = 8'hAB;  // minterms 0,1,3,5,7

  logic [IMG_W-1:0] img_a, img_b, img_c;

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // x = in_x[2], y = in_x[1], z = in_x[0]
    // A: f1 = xz + xy' + y'z + x'yz', out0 true, out1 complement
    img_a = {arow(3'b101, 3'b000), arow(3'b100, 3'b010), arow(3'b001, 3'b010),
             arow(3'b010, 3'b101), 2'b11, 2'b11, 2'b11, 2'b11, 2'b01};
    // B: f2 = z + x'y', plus an all-intact term on both outputs, unused all-blown term
    img_b = {arow(3'b001, 3'b000), arow(3'b000, 3'b110), arow(3'b111, 3'b111),
             arow(3'b000, 3'b000), 2'b11, 2'b11, 2'b11, 2'b00, 2'b01};
    // C: out0 has no terms, out1 only the all-blown term, both true polarity
    img_c = {arow(3'b111, 3'b111), arow(3'b111, 3'b111), arow(3'b111, 3'b111),
             arow(3'b000, 3'b000), 2'b00, 2'b00, 2'b00, 2'b10, 2'b11};

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg_ok", {7'd0, cfg_ok}, 8'd0);
    chk("R1 ld_rdy", {7'd0, ld_rdy}, 8'd1);
    sweep("R1 out after reset", 8'h00, 8'h00);

    // Partial load: outputs must stay low.
    send_range(img_a, IMG_W-1, 17);
    @(negedge clk);
    chk("R8 cfg_ok mid-load", {7'd0, cfg_ok}, 8'd0);
    sweep("R8 out mid-load", 8'h00, 8'h00);

    // Erase and a beat in the same cycle: the beat must be refused.
    @(negedge clk);
    erase = 1'b1;
    ld_vld = 1'b1;
    ld_bit = 1'b0;
    #1 chk("R9 ld_rdy during erase", {7'd0, ld_rdy}, 8'd0);
    @(posedge clk);
    #1 begin erase = 1'b0; ld_vld = 1'b0; end
    @(negedge clk);
    chk("R9 cfg_ok after erase", {7'd0, cfg_ok}, 8'd0);
    chk("R9 ld_rdy after erase", {7'd0, ld_rdy}, 8'd1);

    // Full load of A, checking completion timing.
    send_range(img_a, IMG_W-1, 1);
    @(negedge clk);
    chk("R3 not complete one beat short", {7'd0, cfg_ok}, 8'd0);
    send_range(img_a, 0, 0);
    @(negedge clk);
    chk("R3 complete after last beat", {7'd0, cfg_ok}, 8'd1);
    chk("R11 ld_rdy when programmed", {7'd0, ld_rdy}, 8'd0);
    sweep("R4 R6 R7 config A f1 / ~f1", F1, ~F1);

    // Offered beats while programmed change nothing.
    for (int k = 0; k < 40; k++) send(1'b0);
    @(negedge clk);
    chk("R11 still programmed", {7'd0, cfg_ok}, 8'd1);
    sweep("R11 config A unchanged", F1, ~F1);

    // Erase after programming.
    do_erase();
    @(negedge clk);
    chk("R9 cfg_ok cleared", {7'd0, cfg_ok}, 8'd0);
    chk("R9 ld_rdy back", {7'd0, ld_rdy}, 8'd1);
    sweep("R9 out blank after erase", 8'h00, 8'h00);

    // Config B: all-intact term contributes nothing.
    send_range(img_b, IMG_W-1, 0);
    @(negedge clk);
    chk("R3 config B complete", {7'd0, cfg_ok}, 8'd1);
    sweep("R5 R7 config B f2 / ~f2", F2, ~F2);

    // Config C: empty output and all-blown term.
    do_erase();
    send_range(img_c, IMG_W-1, 0);
    @(negedge clk);
    chk("R3 config C complete", {7'd0, cfg_ok}, 8'd1);
    sweep("R5 R6 config C empty / constant", 8'h00, 8'hFF);

    // Combinational response between edges.
    @(negedge clk);
    do_erase();
    send_range(img_a, IMG_W-1, 0);
    @(negedge clk);
    in_x = 3'd2;
    #0.5 chk("R10 immediate 010", {6'd0, out_f}, {6'd0, 2'b01});
    in_x = 3'd3;
    #0.5 chk("R10 immediate 011", {6'd0, out_f}, {6'd0, 2'b10});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule